// File: doc/BRIEF.md
# Per-Line Palette Colour Mapper

This block turns a stream of 4-bit pixel indices into 12-bit RGB colours. It holds sixteen palettes of sixteen entries each. A table with one entry per display line says which palette each line uses. When a line begins, the block looks up that line's palette number and keeps it until the next line begins. Every valid pixel of the line is then mapped through that palette. Because the palette can change from one line to the next, the screen can show far more than sixteen colours, and software can retime colour changes line by line.

A processor-side write port fills both the palettes and the per-line table. Pixel indices come in with a pixel-valid strobe. A line-start strobe carries the number of the line that is starting. Sync timing and framebuffer fetch belong to neighbouring blocks.

Top module: `line_palette_map`

## Requirements
- R1: While reset is asserted, and on the first output cycle after reset, `out_valid` is 0 and `out_rgb` is 0.
- R2: A pixel presented with `pix_valid` high at a rising edge appears on `out_valid`/`out_rgb` after exactly that edge, which is one cycle of latency.
- R3: `out_rgb` equals bits [11:0] of the selected 16-bit palette entry. Red is in [11:8], green in [7:4] and blue in [3:0]. Bits [15:12] of an entry have no effect on the output.
- R4: On a cycle with `line_start` high, the palette number is read from table entry `line_num`. It is held for all later pixels until the next `line_start`, even if that table entry is rewritten in between.
- R5: A pixel presented in the same cycle as `line_start` is mapped through the palette of the line that is starting.
- R6: A palette write is seen by every lookup at a later edge. A lookup of the same entry at the same edge as the write returns the old value.
- R7: With `cpu_we` high and `cpu_tab` = 0, `cpu_wdata` is stored as palette entry `cpu_addr`, where `cpu_addr[7:4]` is the palette and `cpu_addr[3:0]` the colour index. With `cpu_tab` = 1, `cpu_wdata[3:0]` becomes the palette number of line `cpu_addr` (0 to 199).
- R8: A `line_start` with `line_num` of 200 or more selects palette 0.
- R9: In any cycle where `out_valid` is 0, `out_rgb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Strobe marking the start of a line |
| line_num | input | 8 | Number of the line that is starting |
| pix_valid | input | 1 | Pixel index is valid this cycle |
| pix_idx | input | 4 | Pixel colour index |
| cpu_we | input | 1 | Write enable for the processor port |
| cpu_tab | input | 1 | 1 selects the line table, 0 the palettes |
| cpu_addr | input | 8 | Entry address |
| cpu_wdata | input | 16 | Write data |
| out_valid | output | 1 | Colour output is valid |
| out_rgb | output | 12 | Colour, red high, blue low |

## Verification
A corrupted held palette number shows as wrong colours on every remaining pixel of the line. The first valid pixel after the fault is wrong, one cycle after it enters. A line-table or palette entry stored at the wrong place shows only when a later line or pixel reads that place. For that reason the bench walks every colour index of several lines, lines that map to different palettes. A bad latency or bypass order shows up at once around line starts and same-cycle writes, where old and new values differ.

// File: rtl/line_palette_map.sv
module line_palette_map #(
  parameter int LINES = 200,
  parameter int NPAL  = 16,
  parameter int IDX_W = 4,
  parameter int ENT_W = 16,
  parameter int COL_W = 12,
  localparam int SEL_W   = $clog2(NPAL),
  localparam int PADDR_W = SEL_W + IDX_W,
  localparam int LN_W    = $clog2(LINES),
  localparam int AW      = (PADDR_W > LN_W) ? PADDR_W : LN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [LN_W-1:0]  line_num,
  input  logic             pix_valid,
  input  logic [IDX_W-1:0] pix_idx,
  input  logic             cpu_we,
  input  logic             cpu_tab,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [ENT_W-1:0] cpu_wdata,
  output logic             out_valid,
  output logic [COL_W-1:0] out_rgb
);

  localparam int PAL_DEPTH = NPAL * (1 << IDX_W);

  logic [ENT_W-1:0] pal_mem [PAL_DEPTH];
  logic [SEL_W-1:0] tab_mem [LINES];
  logic [SEL_W-1:0] sel_q;

  wire              line_ok = int'(line_num) < LINES;
  wire              addr_ok = int'(cpu_addr) < LINES;
  wire [SEL_W-1:0]  sel_new = line_ok ? tab_mem[line_num] : '0;
  wire [SEL_W-1:0]  sel_use = line_start ? sel_new : sel_q;
  wire [ENT_W-1:0]  entry   = pal_mem[{sel_use, pix_idx}];

  always_ff @(posedge clk)
    if (cpu_we && !cpu_tab)
      pal_mem[cpu_addr[PADDR_W-1:0]] <= cpu_wdata;

  always_ff @(posedge clk)
    if (cpu_we && cpu_tab && addr_ok)
      tab_mem[cpu_addr[LN_W-1:0]] <= cpu_wdata[SEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q     <= '0;
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      sel_q     <= sel_use;
      out_valid <= pix_valid;
      out_rgb   <= pix_valid ? entry[COL_W-1:0] : '0;
    end

endmodule

module line_palette_map_chk #(
  parameter int LINES = 200,
  parameter int SEL_W = 4,
  parameter int LN_W  = 8,
  parameter int COL_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_start,
  input logic [LN_W-1:0]  line_num,
  input logic             pix_valid,
  input logic [SEL_W-1:0] sel_q,
  input logic             out_valid,
  input logic [COL_W-1:0] out_rgb
);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (out_valid == 1'b0 && out_rgb == '0));

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(pix_valid));

  a_r9_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_rgb == '0);

  a_r4_select_held: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(sel_q));

  a_r8_high_line_pal0: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && int'(line_num) >= LINES) |=> sel_q == '0);

endmodule

bind line_palette_map line_palette_map_chk #(
  .LINES(LINES), .SEL_W(SEL_W), .LN_W(LN_W), .COL_W(COL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
  .pix_valid(pix_valid), .sel_q(sel_q), .out_valid(out_valid), .out_rgb(out_rgb)
);

// File: tb/sim_line_palette_map.sv
module sim_line_palette_map;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [7:0]  line_num = '0;
  logic        pix_valid = 1'b0;
  logic [3:0]  pix_idx = '0;
  logic        cpu_we = 1'b0;
  logic        cpu_tab = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        out_valid;
  logic [11:0] out_rgb;

  logic [15:0] pal_m [256];
  logic [3:0]  tab_m [200];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  line_palette_map u0 (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic idle();
    line_start = 0; pix_valid = 0; cpu_we = 0; cpu_tab = 0;
    line_num = '0; pix_idx = '0; cpu_addr = '0; cpu_wdata = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pal_wr(input int a, input logic [15:0] d);
    cpu_we = 1; cpu_tab = 0; cpu_addr = 8'(a); cpu_wdata = d;
    tick(); idle(); pal_m[a] = d;
  endtask

  task automatic tab_wr(input int l, input logic [3:0] p);
    cpu_we = 1; cpu_tab = 1; cpu_addr = 8'(l); cpu_wdata = {12'hABC, p};
    tick(); idle(); tab_m[l] = p;
  endtask

  task automatic start_line(input int l);
    line_start = 1; line_num = 8'(l); tick(); idle();
  endtask

  task automatic pix(input string tag, input logic [3:0] i, input int p);
    pix_valid = 1; pix_idx = i; tick(); idle();
    chk(tag, {31'd0, out_valid}, 32'd1);
    chk(tag, {20'd0, out_rgb}, {20'd0, pal_m[p*16 + i][11:0]});
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 valid in reset", {31'd0, out_valid}, 0);
    chk("R1 rgb in reset", {20'd0, out_rgb}, 0);
    rst_n = 1; tick();
    chk("R1 valid after reset", {31'd0, out_valid}, 0);
    chk("R1 rgb after reset", {20'd0, out_rgb}, 0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < 256; a++)
      pal_wr(a, 16'hF000 | 16'((a * 397 + 91) & 16'h0FFF));
    for (int l = 0; l < 200; l++) tab_wr(l, 4'((l * 7 + 3) % 16));
  endtask

  task automatic t_walk();
    for (int l = 0; l < 200; l += 41) begin
      start_line(l);
      for (int i = 0; i < 16; i++) pix("R3 R7 colour walk", 4'(i), int'(tab_m[l]));
    end
  endtask

  task automatic t_latency();
    start_line(5);
    pix_valid = 1; pix_idx = 4'd9;
    chk("R2 before edge", {31'd0, out_valid}, 0);
    tick(); idle();
    chk("R2 after edge", {20'd0, out_rgb}, {20'd0, pal_m[tab_m[5]*16 + 9][11:0]});
    tick();
    chk("R2 drops after one", {31'd0, out_valid}, 0);
    chk("R9 blank rgb", {20'd0, out_rgb}, 0);
  endtask

  task automatic t_same_cycle();
    start_line(10);
    line_start = 1; line_num = 8'd11; pix_valid = 1; pix_idx = 4'd6;
    tick(); idle();
    chk("R5 new line palette", {20'd0, out_rgb}, {20'd0, pal_m[tab_m[11]*16 + 6][11:0]});
  endtask

  task automatic t_hold();
    int p;
    start_line(20);
    p = int'(tab_m[20]);
    tab_wr(20, 4'(p + 1));
    pix("R4 held across table write", 4'd2, p);
    start_line(20);
    pix("R4 R7 new table entry", 4'd2, (p + 1) % 16);
  endtask

  task automatic t_pal_write();
    int p, a;
    start_line(30);
    p = int'(tab_m[30]); a = p * 16 + 4;
    cpu_we = 1; cpu_tab = 0; cpu_addr = 8'(a); cpu_wdata = 16'h0E5A;
    pix_valid = 1; pix_idx = 4'd4;
    tick(); idle();
    chk("R6 same edge old", {20'd0, out_rgb}, {20'd0, pal_m[a][11:0]});
    pal_m[a] = 16'h0E5A;
    pix("R6 next lookup new", 4'd4, p);
    pal_wr(a, 16'h5123);
    pix("R3 top bits ignored", 4'd4, p);
  endtask

  task automatic t_high_line();
    start_line(230);
    pix("R8 line above range", 4'd13, 0);
    start_line(200);
    pix("R8 first line out of range", 4'd1, 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_fill(); t_walk(); t_latency(); t_same_cycle();
        t_hold(); t_pal_write(); t_high_line();
      end
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule